// File: doc/BRIEF.md
# Subsystem Word Transfer Handshake Controller

This block paces every word that moves between a bus terminal and its host subsystem over a shared 16-bit parallel bus. The protocol engine hands it one word-transfer request at a time over a valid/ready pair, together with a direction flag. The controller then lowers an active-low request toward the subsystem and waits for the subsystem's active-low grant. Once the grant arrives it runs a fixed-length transfer window. The acknowledge stays low for the whole window, a two-clock data strobe sits in its middle, and a read/write line turns the bus buffers around when the word flows from the subsystem toward the terminal. A single response pulse reports whether the word completed or was dropped.

The grant is asynchronous to the 12 MHz clock, so it passes through a synchronizer first. It only has to be seen once. After the transfer has begun the subsystem may release it. If no grant shows up within a parameterised number of clocks, the request is withdrawn, the word is abandoned, and a sticky active-low handshake-fail flag drops. That flag rises again only when the protocol engine starts a new protocol sequence. That event also produces a two-clock active-low new-sequence pulse toward the subsystem.

Back-pressure rules: a word request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` must stay high until that edge. `req_ready` is high only while no word is pending. It is already high again in the cycle that carries the response, so back-to-back words lose no cycle. The response is a plain one-cycle pulse and cannot be stalled.

Top module: `subsys_xfer_hs`

## Requirements
- R1: While reset is low and in the first cycle after it, `dtreq_n`, `dtack_n`, `dstrb_n`, `nseq_n` and `hsfail_n` are high, `rd_wr` is low and `req_ready` is high.
- R2: `req_ready` is low from the cycle after a word is accepted until the cycle that carries its response. While it is low, no other request is taken.
- R3: If the grant is driven low `d` cycles after the first cycle of `dtreq_n` low, and `d + SYNC_STAGES + 1 <= TIMEOUT_CYC`, then `dtreq_n` stays low for exactly `d + SYNC_STAGES + 1` cycles and rises in the cycle where `dtack_n` falls.
- R4: `dtack_n` is low for exactly `XFER_LEN` consecutive cycles after a granted request, and never in the same cycle as `dtreq_n`. Releasing the grant after the transfer has started does not shorten it.
- R5: `dstrb_n` is low for exactly `STB_LEN` cycles per transfer, starting `(XFER_LEN-STB_LEN)/2` cycles after the first `dtack_n` low cycle.
- R6: `rd_wr` is high exactly in the cycles where `dtreq_n` or `dtack_n` is low for a word accepted with `req_dir = 1` (data from the subsystem). It is low in every other cycle.
- R7: Without a grant in time, `dtreq_n` stays low for exactly `TIMEOUT_CYC` cycles and then rises, no acknowledge follows, and `hsfail_n` falls in the cycle after the last request cycle.
- R8: Once low, `hsfail_n` stays low across later successful words until a new sequence is started.
- R9: A `seq_start` pulse sampled at a clock edge drives `nseq_n` low for `NSEQ_LEN` cycles starting in the next cycle. `hsfail_n` is high from that first cycle; a clear and a timeout on the same edge resolve to clear.
- R10: Each accepted word produces exactly one one-cycle `rsp_valid` pulse: one cycle after the last acknowledge cycle with `rsp_ok = 1`, or one cycle after the last request cycle with `rsp_ok = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Protocol engine offers one word transfer |
| req_ready | output | 1 | Controller can take a word request |
| req_dir | input | 1 | 1 = word comes from the subsystem, 0 = word goes to it |
| rsp_valid | output | 1 | One-cycle pulse: word finished or abandoned |
| rsp_ok | output | 1 | 1 = transferred, 0 = timed out (valid with rsp_valid) |
| seq_start | input | 1 | Start of a new protocol sequence |
| gnt_n | input | 1 | Active-low grant from the subsystem (asynchronous) |
| dtreq_n | output | 1 | Active-low transfer request to the subsystem |
| dtack_n | output | 1 | Active-low transfer acknowledge, low for the whole window |
| dstrb_n | output | 1 | Active-low mid-window data strobe |
| rd_wr | output | 1 | High when the subsystem must drive the bus |
| nseq_n | output | 1 | Active-low new-sequence pulse |
| hsfail_n | output | 1 | Sticky active-low handshake-fail flag |

## Verification
The hardest situation to reach is the edge of the timeout window. There, the grant crosses the synchronizer on the same clock edge that the wait counter runs out, so one cycle decides between a transfer and an abandoned word. The bench sweeps the grant delay one cycle at a time, from zero to past the window, for both directions. Each delay's outcome, request length, acknowledge length and strobe position are computed from the synchronizer depth and the timeout. Between sweeps the bench leaves the fail flag set across a successful word and then clears it with a new-sequence pulse. This covers both the sticky behaviour and the clearing pulse.

// File: rtl/sxh_pkg.sv
package sxh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } sxh_state_e;
endpackage

// File: rtl/sxh_sync.sv
module sxh_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh[0] <= RST_VAL;
    else        sh[0] <= din;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) sh[g] <= RST_VAL;
        else        sh[g] <= sh[g-1];
      end
    end
  endgenerate

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/sxh_word_fsm.sv
module sxh_word_fsm
  import sxh_pkg::*;
#(
  parameter int TIMEOUT_CYC = 48,
  parameter int XFER_LEN    = 6,
  parameter int STB_LEN     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_dir,
  input  logic gnt,
  output logic req_ready,
  output logic in_req,
  output logic in_xfer,
  output logic strobe,
  output logic dir_q,
  output logic rsp_valid,
  output logic rsp_ok,
  output logic tmo_hit
);
  localparam int WAIT_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int PH_W    = $clog2(XFER_LEN + 1);
  localparam int STB_OFS = (XFER_LEN - STB_LEN) / 2;
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(TIMEOUT_CYC - 1);
  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(XFER_LEN - 1);
  localparam logic [PH_W-1:0]   STB_LO    = PH_W'(STB_OFS);
  localparam logic [PH_W-1:0]   STB_HI    = PH_W'(STB_OFS + STB_LEN);

  sxh_state_e        state;
  logic [WAIT_W-1:0] wcnt;
  logic [PH_W-1:0]   ph;

  assign req_ready = (state == ST_IDLE);
  assign in_req    = (state == ST_REQ);
  assign in_xfer   = (state == ST_XFER);
  assign strobe    = in_xfer && (ph >= STB_LO) && (ph < STB_HI);
  assign tmo_hit   = in_req && !gnt && (wcnt == WAIT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wcnt      <= '0;
      ph        <= '0;
      dir_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state <= ST_REQ;
            wcnt  <= '0;
            dir_q <= req_dir;
          end
        end
        ST_REQ: begin
          if (gnt) begin
            state <= ST_XFER;
            ph    <= '0;
          end else if (wcnt == WAIT_LAST) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_ok    <= 1'b0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (ph == PH_LAST) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_ok    <= 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sxh_seq.sv
module sxh_seq #(
  parameter int NSEQ_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_start,
  input  logic tmo_hit,
  output logic nseq_n,
  output logic hsfail_n
);
  localparam int NC_W = $clog2(NSEQ_LEN + 1);

  logic [NC_W-1:0] ncnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ncnt     <= '0;
      hsfail_n <= 1'b1;
    end else begin
      if (seq_start)         ncnt <= NC_W'(NSEQ_LEN);
      else if (ncnt != '0)   ncnt <= ncnt - 1'b1;
      if (seq_start)         hsfail_n <= 1'b1;
      else if (tmo_hit)      hsfail_n <= 1'b0;
    end
  end

  assign nseq_n = (ncnt == '0);
endmodule

// File: rtl/subsys_xfer_hs.sv
module subsys_xfer_hs #(
  parameter int TIMEOUT_CYC = 48,
  parameter int XFER_LEN    = 6,
  parameter int STB_LEN     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int NSEQ_LEN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  input  logic req_dir,
  output logic rsp_valid,
  output logic rsp_ok,
  input  logic seq_start,
  input  logic gnt_n,
  output logic dtreq_n,
  output logic dtack_n,
  output logic dstrb_n,
  output logic rd_wr,
  output logic nseq_n,
  output logic hsfail_n
);
  logic gnt_n_s, in_req, in_xfer, strobe, dir_q, tmo_hit;

  sxh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_gsync (
    .clk(clk), .rst_n(rst_n), .din(gnt_n), .dout(gnt_n_s)
  );

  sxh_word_fsm #(
    .TIMEOUT_CYC(TIMEOUT_CYC), .XFER_LEN(XFER_LEN), .STB_LEN(STB_LEN)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
    .gnt(!gnt_n_s), .req_ready(req_ready), .in_req(in_req),
    .in_xfer(in_xfer), .strobe(strobe), .dir_q(dir_q),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .tmo_hit(tmo_hit)
  );

  sxh_seq #(.NSEQ_LEN(NSEQ_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .tmo_hit(tmo_hit),
    .nseq_n(nseq_n), .hsfail_n(hsfail_n)
  );

  assign dtreq_n = !in_req;
  assign dtack_n = !in_xfer;
  assign dstrb_n = !strobe;
  assign rd_wr   = dir_q && (in_req || in_xfer);
endmodule

// File: rtl/subsys_xfer_hs_chk.sv
module subsys_xfer_hs_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic seq_start,
  input logic rsp_valid,
  input logic dtreq_n,
  input logic dtack_n,
  input logic dstrb_n,
  input logic rd_wr,
  input logic nseq_n,
  input logic hsfail_n
);
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dtreq_n && dtack_n)); // R2
  AST_REQ_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtreq_n && !dtack_n)); // R4
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> $past(!dtreq_n)); // R3
  AST_STB_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !dstrb_n |-> !dtack_n); // R5
  AST_RW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wr |-> (!dtreq_n || !dtack_n)); // R6
  AST_FAIL_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsfail_n) |-> ($past(!dtreq_n) && dtreq_n)); // R7
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsfail_n && !seq_start) |=> !hsfail_n); // R8
  AST_NSEQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nseq_n) |-> hsfail_n); // R9
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
endmodule

bind subsys_xfer_hs subsys_xfer_hs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .seq_start(seq_start),
  .rsp_valid(rsp_valid), .dtreq_n(dtreq_n), .dtack_n(dtack_n),
  .dstrb_n(dstrb_n), .rd_wr(rd_wr), .nseq_n(nseq_n), .hsfail_n(hsfail_n)
);

// File: tb/subsys_xfer_hs_bench.sv
module subsys_xfer_hs_bench;
  localparam int TO  = 8;
  localparam int XL  = 6;
  localparam int SL  = 2;
  localparam int SS  = 2;
  localparam int NL  = 2;
  localparam int OFS = (XL - SL) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_dir = 1'b0, seq_start = 1'b0, gnt_n = 1'b1;
  logic req_ready, rsp_valid, rsp_ok, dtreq_n, dtack_n, dstrb_n, rd_wr, nseq_n, hsfail_n;

  int checks = 0;
  int fails  = 0;
  bit exp_fail = 1'b0;

  always #5 clk = ~clk;

  subsys_xfer_hs #(
    .TIMEOUT_CYC(TO), .XFER_LEN(XL), .STB_LEN(SL), .SYNC_STAGES(SS), .NSEQ_LEN(NL)
  ) u_subsys_xfer_hs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dir(req_dir), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .seq_start(seq_start), .gnt_n(gnt_n), .dtreq_n(dtreq_n), .dtack_n(dtack_n),
    .dstrb_n(dstrb_n), .rd_wr(rd_wr), .nseq_n(nseq_n), .hsfail_n(hsfail_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_word(input logic dir, input int d);
    int req_cnt = 0, ack_cnt = 0, stb_cnt = 0, ack_first = -1, stb_first = -1;
    int rw_bad = 0, rdy_bad = 0, got = 0, ok = 0;
    bit busy;
    bit exp_ok = (d + SS + 1 <= TO);
    @(negedge clk);
    chk("R2 ready before word", int'(req_ready), 1);
    req_valid = 1'b1;
    req_dir   = dir;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (!dtreq_n) req_cnt++;
      if (!dtack_n) begin
        if (ack_first < 0) ack_first = k;
        ack_cnt++;
      end
      if (!dstrb_n) begin
        if (stb_first < 0) stb_first = k;
        stb_cnt++;
      end
      busy = !dtreq_n || !dtack_n;
      if (rd_wr != (dir && busy)) rw_bad++;
      if (req_ready && !rsp_valid) rdy_bad++;
      if (rsp_valid) begin
        got = 1;
        ok  = int'(rsp_ok);
        break;
      end
      if (k == d) gnt_n = 1'b0;
      if (ack_first >= 0 && k == ack_first) gnt_n = 1'b1;  // early release, R4
      @(negedge clk);
    end
    gnt_n = 1'b1;
    if (!exp_ok) exp_fail = 1'b1;
    chk($sformatf("R10 response seen d=%0d", d), got, 1);
    chk($sformatf("R10 rsp_ok d=%0d", d), ok, int'(exp_ok));
    chk($sformatf("R2 ready low while busy d=%0d", d), rdy_bad, 0);
    chk($sformatf("R6 rd_wr dir=%0d d=%0d", dir, d), rw_bad, 0);
    chk($sformatf("R8 hsfail_n d=%0d", d), int'(hsfail_n), int'(!exp_fail));
    if (exp_ok) begin
      chk($sformatf("R3 request length d=%0d", d), req_cnt, d + SS + 1);
      chk($sformatf("R3 ack start d=%0d", d), ack_first, d + SS + 1);
      chk($sformatf("R4 ack length d=%0d", d), ack_cnt, XL);
      chk($sformatf("R5 strobe length d=%0d", d), stb_cnt, SL);
      chk($sformatf("R5 strobe offset d=%0d", d), stb_first - ack_first, OFS);
    end else begin
      chk($sformatf("R7 request length d=%0d", d), req_cnt, TO);
      chk($sformatf("R7 no ack d=%0d", d), ack_cnt, 0);
    end
    repeat (SS + 2) @(negedge clk);
  endtask

  task automatic pulse_seq();
    @(negedge clk);
    seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
    exp_fail = 1'b0;
    for (int i = 0; i < NL; i++) begin
      chk($sformatf("R9 nseq_n low cycle %0d", i), int'(nseq_n), 0);
      chk($sformatf("R9 hsfail_n cleared cycle %0d", i), int'(hsfail_n), 1);
      @(negedge clk);
    end
    chk("R9 nseq_n back high", int'(nseq_n), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 dtreq_n in reset", int'(dtreq_n), 1);
    chk("R1 dtack_n in reset", int'(dtack_n), 1);
    chk("R1 dstrb_n in reset", int'(dstrb_n), 1);
    chk("R1 nseq_n in reset", int'(nseq_n), 1);
    chk("R1 hsfail_n in reset", int'(hsfail_n), 1);
    chk("R1 rd_wr in reset", int'(rd_wr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(req_ready), 1);
    chk("R1 dtreq_n after reset", int'(dtreq_n), 1);
    for (int dir = 0; dir < 2; dir++) begin
      for (int d = 0; d <= TO + 1; d++) do_word(dir[0], d);
      do_word(dir[0], 0);  // R8: success after a failure keeps the flag low
      pulse_seq();
    end
    do_word(1'b0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule